// File: doc/BRIEF.md
# Per-Device SPI Bit Clock and Chip-Select Timer

This block times the serial clock and the chip-select lines of a multi-device SPI master. Each device slot holds a 32-bit timing word that sets its bit-clock rate code and three waits, all in input clock cycles: a setup wait between select assertion and the first clock edge, a hold wait after the last bit, and a gap during which no new transfer may start. A start request names a device and a bit count. The block then drives that device's select line low and waits the setup count. It then produces the requested number of bit periods on SCLK, with a one-cycle clock-enable pulse per bit for an external shift datapath. It waits the hold count, releases the select, and enforces the gap before it accepts the next start.

The bit rate comes from a 9-bit phase accumulator that adds an effective step on every clock. One bit period is 512/step cycles. SCLK leaves its idle level for the second half of each period. The idle level is the per-device polarity input of the last selected device. The start request is a valid/ready handshake. A requester holds `start_valid` and its fields steady until it sees `start_ready` high at a clock edge. `start_ready` is high only while the block is idle, so no request is accepted while a transfer or its gap is running. Timing words are plain register writes and take effect at the next accepted start.

Top module: `spi_cs_timing`

## Requirements
- R1: Each device has its own timing word, written when `cfg_we` is high at a clock edge with `cfg_dev` naming the device. Bits [31:24] hold the rate code, [23:16] the setup count, [15:8] the hold count and [7:0] the gap count. Writing one device's word leaves the timing of the others unchanged.
- R2: With effective step E, one bit period lasts P = 512/E cycles. Within each period SCLK is at its idle level for the first P/2 cycles and at the opposite level for the last P/2 cycles.
- R3: A rate code of 255 gives step 256 and a code of 0 gives step 1. Any other code that is not a power of two is rounded down to its highest set bit.
- R4: The select line goes low in the first cycle after acceptance. SCLK first leaves idle after S + P/2 cycles with the select low, where S is the setup count.
- R5: The select line stays low for exactly S + N·P + H cycles, where N is the bit count and H is the hold count. N = 0 produces no clock edges.
- R6: `bit_en` gives exactly N single-cycle pulses per transfer. Each pulse falls in the cycle in which SCLK returns to idle at the end of a bit.
- R7: After the select rises, `start_ready` stays low for exactly G cycles, where G is the gap count. A request held valid across that time is accepted in the first ready cycle, so the select falls again G+1 cycles after it rose.
- R8: `start_ready` is low whenever a select line is low. A start is taken only on a clock edge with both `start_valid` and `start_ready` high.
- R9: While idle, SCLK equals `dev_cpol` of the last selected device (device 0 after reset). No select line is low while SCLK is away from that level.
- R10: Select lines are active low, and at most one is low: the line of the device named at acceptance.
- R11: The timing word is captured when a start is accepted. A write to the same device during the transfer changes only later transfers.
- R12: During reset and right after it, all select lines are high, `bit_en` is low, `start_ready` is high and SCLK equals `dev_cpol[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_dev | input | DEV_W | Device whose word is written |
| cfg_word | input | 32 | Timing word: code, setup, hold, gap |
| dev_cpol | input | NUM_CS | Per-device SCLK idle level |
| start_valid | input | 1 | Start request valid |
| start_ready | output | 1 | Block idle, request is taken this edge |
| start_dev | input | DEV_W | Device to select |
| start_bits | input | BITS_W | Number of bits to clock |
| bit_en | output | 1 | One-cycle pulse per completed bit |
| sclk | output | 1 | Serial clock level |
| cs_n | output | NUM_CS | Active-low select lines |

## Verification
The select line is registered, so it falls in the first cycle after the accepting edge. The bench drives and samples on the falling clock edge and counts from that first cycle. Every select-low cycle, every SCLK-active cycle and every `bit_en` pulse is counted until `start_ready` returns. The bench computes the expected totals from S, H, G, N and P, which are S+N·P+H, N, N·P/2, S+P/2 and G. The last `bit_en` pulse lands one cycle after the final SCLK-active cycle. It can therefore fall in the first cycle with the select released, so the pulse count runs through the gap and the first ready cycle.

// File: rtl/spi_cst_pkg.sv
package spi_cst_pkg;

  localparam int CODE_W = 8;
  localparam int CNT_W  = 8;
  localparam int ACC_W  = 9;
  localparam int WORD_W = 4 * CNT_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  // Field order matches the timing word: code in the top byte, gap at the bottom.
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  setup;
    logic [CNT_W-1:0]  hold;
    logic [CNT_W-1:0]  gap;
  } dev_param_t;

  // Accumulator step for a rate code: 255 means 256, 0 means 1,
  // any other value is rounded down to its highest set bit.
  function automatic logic [ACC_W-1:0] rate_step(input logic [CODE_W-1:0] code);
    logic [ACC_W-1:0] r;
    r = '0;
    if (code == '1) begin
      r = ACC_W'(1) << (ACC_W - 1);
    end else if (code == '0) begin
      r = ACC_W'(1);
    end else begin
      for (int i = 0; i < CODE_W; i++) begin
        if (code[i]) r = ACC_W'(1) << i;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_cst_param_bank.sv
module spi_cst_param_bank
  import spi_cst_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int DEV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DEV_W-1:0]  rd_dev,
  output dev_param_t        rd_param
);

  dev_param_t slot_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_dev == DEV_W'(g))) begin
        slot_q[g] <= dev_param_t'(wr_word);
      end
    end
  end

  always_comb begin
    rd_param = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_dev == DEV_W'(i)) rd_param = slot_q[i];
    end
  end

endmodule

// File: rtl/spi_cst_rate_gen.sv
module spi_cst_rate_gen
  import spi_cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] step,
  output logic             carry,
  output logic             phase_msb,
  output logic             edge_en
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum       = {1'b0, acc_q} + {1'b0, step};
  assign carry     = run & sum[ACC_W];
  assign phase_msb = acc_q[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      edge_en <= 1'b0;
    end else begin
      acc_q   <= run ? sum[ACC_W-1:0] : '0;
      edge_en <= carry;
    end
  end

endmodule

// File: rtl/spi_cst_seq.sv
module spi_cst_seq
  import spi_cst_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int BITS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [DEV_W-1:0]  start_dev,
  input  logic [BITS_W-1:0] start_bits,
  input  dev_param_t        sel_param,
  input  logic              carry,
  output logic              run,
  output logic              active,
  output logic [ACC_W-1:0]  step,
  output logic [DEV_W-1:0]  dev
);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic [ACC_W-1:0]  step_q, step_d;
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic [CNT_W-1:0]  gap_q, gap_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    dev_d   = dev_q;
    step_d  = step_q;
    hold_d  = hold_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_valid) begin
          dev_d  = start_dev;
          step_d = rate_step(sel_param.code);
          hold_d = sel_param.hold;
          gap_d  = sel_param.gap;
          bits_d = start_bits;
          if (sel_param.setup != '0) begin
            state_d = ST_SETUP;
            cnt_d   = sel_param.setup;
          end else if (start_bits != '0) begin
            state_d = ST_XFER;
          end else if (sel_param.hold != '0) begin
            state_d = ST_HOLD;
            cnt_d   = sel_param.hold;
          end else if (sel_param.gap != '0) begin
            state_d = ST_GAP;
            cnt_d   = sel_param.gap;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (bits_q != '0) begin
          state_d = ST_XFER;
        end else if (hold_q != '0) begin
          state_d = ST_HOLD;
          cnt_d   = hold_q;
        end else if (gap_q != '0) begin
          state_d = ST_GAP;
          cnt_d   = gap_q;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (carry) begin
          if (bits_q > BITS_W'(1)) begin
            bits_d = bits_q - BITS_W'(1);
          end else if (hold_q != '0) begin
            bits_d  = '0;
            state_d = ST_HOLD;
            cnt_d   = hold_q;
          end else if (gap_q != '0) begin
            bits_d  = '0;
            state_d = ST_GAP;
            cnt_d   = gap_q;
          end else begin
            bits_d  = '0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (gap_q != '0) begin
          state_d = ST_GAP;
          cnt_d   = gap_q;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      dev_q   <= '0;
      step_q  <= ACC_W'(1);
      hold_q  <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      dev_q   <= dev_d;
      step_q  <= step_d;
      hold_q  <= hold_d;
      gap_q   <= gap_d;
    end
  end

  assign start_ready = (state_q == ST_IDLE);
  assign run         = (state_q == ST_XFER);
  assign active      = (state_q == ST_SETUP) || (state_q == ST_XFER) || (state_q == ST_HOLD);
  assign step        = step_q;
  assign dev         = dev_q;

endmodule

// File: rtl/spi_cs_timing.sv
module spi_cs_timing
  import spi_cst_pkg::*;
#(
  parameter  int NUM_CS = 5,
  parameter  int BITS_W = 16,
  localparam int DEV_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [31:0]       cfg_word,
  input  logic [NUM_CS-1:0] dev_cpol,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [DEV_W-1:0]  start_dev,
  input  logic [BITS_W-1:0] start_bits,
  output logic              bit_en,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n
);

  dev_param_t       rd_param;
  logic             carry;
  logic             phase_msb;
  logic             run;
  logic             active;
  logic [ACC_W-1:0] step;
  logic [DEV_W-1:0] seq_dev;
  logic             cpol_sel;

  spi_cst_param_bank #(
    .NUM_CS (NUM_CS),
    .DEV_W  (DEV_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_dev   (cfg_dev),
    .wr_word  (cfg_word),
    .rd_dev   (start_dev),
    .rd_param (rd_param)
  );

  spi_cst_seq #(
    .DEV_W  (DEV_W),
    .BITS_W (BITS_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .start_dev   (start_dev),
    .start_bits  (start_bits),
    .sel_param   (rd_param),
    .carry       (carry),
    .run         (run),
    .active      (active),
    .step        (step),
    .dev         (seq_dev)
  );

  spi_cst_rate_gen u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .step      (step),
    .carry     (carry),
    .phase_msb (phase_msb),
    .edge_en   (bit_en)
  );

  always_comb begin
    cpol_sel = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (seq_dev == DEV_W'(i)) cpol_sel = dev_cpol[i];
    end
  end

  assign sclk = cpol_sel ^ (run & phase_msb);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(active && (seq_dev == DEV_W'(g)));
  end

endmodule

// File: rtl/spi_cs_timing_chk.sv
module spi_cs_timing_chk #(
  parameter int NUM_CS = 5,
  parameter int DEV_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ready,
  input logic              bit_en,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] dev_cpol,
  input logic [DEV_W-1:0]  sel_dev
);

  logic idle_lvl;
  logic any_sel;

  always_comb begin
    idle_lvl = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel_dev == DEV_W'(i)) idle_lvl = dev_cpol[i];
    end
  end

  assign any_sel = (cs_n != '1);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1); // R10
  AST_READY_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n) any_sel |-> !start_ready); // R8
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) start_ready |-> (sclk == idle_lvl)); // R9
  AST_SCLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) (sclk != idle_lvl) |-> any_sel); // R9
  AST_BIT_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_en |=> !bit_en); // R6
  AST_BIT_EN_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n) bit_en |-> $past(any_sel)); // R6

endmodule

bind spi_cs_timing spi_cs_timing_chk #(
  .NUM_CS (NUM_CS),
  .DEV_W  (DEV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ready (start_ready),
  .bit_en      (bit_en),
  .sclk        (sclk),
  .cs_n        (cs_n),
  .dev_cpol    (dev_cpol),
  .sel_dev     (seq_dev)
);

// File: tb/spi_cs_timing_bench.sv
`timescale 1ns/1ps
module spi_cs_timing_bench;

  localparam int NUM_CS = 5;
  localparam int BITS_W = 16;
  localparam int DEV_W  = 3;
  localparam int LOOP_MAX = 5000;

  typedef struct packed {
    logic [7:0]  dev;
    logic [7:0]  code;
    logic [7:0]  s;
    logic [7:0]  h;
    logic [7:0]  d;
    logic [15:0] n;
    logic [7:0]  cpol;
    logic [15:0] e_low;
    logic [15:0] e_bits;
    logic [15:0] e_act;
    logic [15:0] e_lead;
    logic [15:0] e_gap;
  } vec_t;

  // e_lead = 16'hFFFF means no clock edge is expected
  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0, 8'd128, 8'd3,   8'd2,   8'd4,   16'd4, 8'd0, 16'd21,  16'd4, 16'd8,   16'd5,   16'd4},
    '{8'd1, 8'd255, 8'd0,   8'd0,   8'd0,   16'd3, 8'd1, 16'd6,   16'd3, 16'd3,   16'd1,   16'd0},
    '{8'd2, 8'd64,  8'd1,   8'd5,   8'd2,   16'd2, 8'd0, 16'd22,  16'd2, 16'd8,   16'd5,   16'd2},
    '{8'd3, 8'd1,   8'd2,   8'd1,   8'd1,   16'd1, 8'd1, 16'd515, 16'd1, 16'd256, 16'd258, 16'd1},
    '{8'd4, 8'd96,  8'd0,   8'd3,   8'd0,   16'd2, 8'd0, 16'd19,  16'd2, 16'd8,   16'd4,   16'd0},
    '{8'd0, 8'd0,   8'd0,   8'd0,   8'd0,   16'd1, 8'd1, 16'd512, 16'd1, 16'd256, 16'd256, 16'd0},
    '{8'd2, 8'd32,  8'd4,   8'd3,   8'd5,   16'd0, 8'd0, 16'd7,   16'd0, 16'd0,   16'hFFFF, 16'd5},
    '{8'd1, 8'd16,  8'd255, 8'd255, 8'd255, 16'd1, 8'd1, 16'd542, 16'd1, 16'd16,  16'd271, 16'd255}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [DEV_W-1:0]  cfg_dev = '0;
  logic [31:0]       cfg_word = '0;
  logic [NUM_CS-1:0] dev_cpol = 5'b10101;
  logic              start_valid = 1'b0;
  logic              start_ready;
  logic [DEV_W-1:0]  start_dev = '0;
  logic [BITS_W-1:0] start_bits = '0;
  logic              bit_en;
  logic              sclk;
  logic [NUM_CS-1:0] cs_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_cs_timing #(.NUM_CS(NUM_CS), .BITS_W(BITS_W)) u_spi_cs_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_dev     (cfg_dev),
    .cfg_word    (cfg_word),
    .dev_cpol    (dev_cpol),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .start_dev   (start_dev),
    .start_bits  (start_bits),
    .bit_en      (bit_en),
    .sclk        (sclk),
    .cs_n        (cs_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input int dev, input logic [31:0] w);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_dev  = DEV_W'(dev);
    cfg_word = w;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  // Starts one transfer from idle and measures it cycle by cycle.
  task automatic run_xfer(input int dev, input int nbits, input bit midw, input logic [31:0] mword,
                          output int low, output int bits, output int act, output int lead,
                          output int gap, output int bad_ready, output int bad_other, output int bad_idle);
    int guard;
    low = 0; bits = 0; act = 0; lead = -1; gap = 0;
    bad_ready = 0; bad_other = 0; bad_idle = 0;
    @(negedge clk);
    start_valid = 1'b1;
    start_dev   = DEV_W'(dev);
    start_bits  = BITS_W'(nbits);
    @(negedge clk);
    start_valid = 1'b0;
    guard = 0;
    while (cs_n[dev] == 1'b0 && guard < LOOP_MAX) begin
      low++;
      if (sclk != dev_cpol[dev]) begin
        act++;
        if (lead < 0) lead = low - 1;
      end
      if (bit_en) bits++;
      if (start_ready) bad_ready++;
      if ((cs_n | (NUM_CS'(1) << dev)) != '1) bad_other++;
      if (midw && low == 2) begin
        cfg_we = 1'b1; cfg_dev = DEV_W'(dev); cfg_word = mword;
      end else begin
        cfg_we = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    while (!start_ready && guard < LOOP_MAX) begin
      if (bit_en) bits++;
      if (sclk != dev_cpol[dev]) bad_idle++;
      gap++;
      guard++;
      @(negedge clk);
    end
    if (bit_en) bits++;
    if (sclk != dev_cpol[dev]) bad_idle++;
    if (guard >= LOOP_MAX) chk("R5 loop guard", guard, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int low, bits, act, lead, gap, br, bo, bi, hi;
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 cs_n in reset", int'(cs_n), 31);
    chk("R12 ready in reset", int'(start_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 cs_n after reset", int'(cs_n), 31);
    chk("R12 bit_en after reset", int'(bit_en), 0);
    chk("R12 ready after reset", int'(start_ready), 1);
    chk("R12 sclk idle is dev0 polarity", int'(sclk), 1);

    for (int v = 0; v < NVEC; v++) begin
      int dv;
      dv = int'(VEC[v].dev);
      dev_cpol[dv] = VEC[v].cpol[0];
      write_word(dv, {VEC[v].code, VEC[v].s, VEC[v].h, VEC[v].d});
      chk("R8 ready before start", int'(start_ready), 1);
      run_xfer(dv, int'(VEC[v].n), 1'b0, 32'd0, low, bits, act, lead, gap, br, bo, bi);
      chk("R5 select low cycles", low, int'(VEC[v].e_low));
      chk("R6 bit_en pulses", bits, int'(VEC[v].e_bits));
      chk("R2 sclk active cycles", act, int'(VEC[v].e_act));
      if (VEC[v].e_lead != 16'hFFFF) chk("R4 setup lead", lead, int'(VEC[v].e_lead));
      else chk("R5 no edge for zero bits", lead, -1);
      chk("R7 gap cycles", gap, int'(VEC[v].e_gap));
      chk("R8 ready low while selected", br, 0);
      chk("R10 other lines stay high", bo, 0);
      chk("R9 idle level after select", bi, 0);
      if (v == 1 || v == 4 || v == 5) chk("R3 code mapping period", act * 2 / int'(VEC[v].n), (v == 1) ? 2 : ((v == 4) ? 8 : 512));
    end

    // R1 separate words per device
    write_word(2, {8'd128, 8'd1, 8'd1, 8'd1});
    write_word(3, {8'd64, 8'd9, 8'd9, 8'd9});
    run_xfer(2, 1, 1'b0, 32'd0, low, bits, act, lead, gap, br, bo, bi);
    chk("R1 dev2 keeps its word", low, 6);
    chk("R1 dev2 gap", gap, 1);
    run_xfer(3, 1, 1'b0, 32'd0, low, bits, act, lead, gap, br, bo, bi);
    chk("R1 dev3 keeps its word", low, 26);
    chk("R1 dev3 gap", gap, 9);

    // R11 write during transfer affects only later transfers
    run_xfer(2, 1, 1'b1, {8'd128, 8'd4, 8'd4, 8'd0}, low, bits, act, lead, gap, br, bo, bi);
    chk("R11 current transfer uses old word", low, 6);
    chk("R11 current gap uses old word", gap, 1);
    run_xfer(2, 1, 1'b0, 32'd0, low, bits, act, lead, gap, br, bo, bi);
    chk("R11 next transfer uses new word", low, 12);
    chk("R11 next gap uses new word", gap, 0);

    // R7 held request is taken in the first ready cycle
    dev_cpol[4] = 1'b0;
    write_word(4, {8'd128, 8'd2, 8'd1, 8'd3});
    @(negedge clk);
    start_valid = 1'b1; start_dev = 3'd4; start_bits = 16'd1;
    @(negedge clk);
    for (int k = 0; k < 100 && cs_n[4] == 1'b0; k++) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 100 && cs_n[4] == 1'b1; k++) begin
      hi++;
      @(negedge clk);
    end
    start_valid = 1'b0;
    chk("R7 back-to-back select gap", hi, 4);
    chk("R8 ready low after second accept", int'(start_ready), 0);
    for (int k = 0; k < 100 && !start_ready; k++) @(negedge clk);
    chk("R8 returns to idle", int'(start_ready), 1);
    chk("R10 all lines high at idle", int'(cs_n), 31);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule